// File: doc/BRIEF.md
# Recalibration Request Handshake Initiator

This block sits on the host side of a memory subsystem. It asks a remote sequencer to reset and recalibrate the memory controller. Two byte-wide register buses connect the two sides. The outgoing bus carries the host's request word. The return bus carries the sequencer's progress word.

A one-cycle start pulse sends the request code. The block then waits until the sequencer reports, in turn, that it has taken the request and that the work is finished. It then withdraws the request and waits for the sequencer to clear its side. The return bus comes from another clock domain, so it passes through a two-stage synchronizer and a stability filter before the state machine acts on it.

Each wait phase is guarded by a cycle counter with a limit set at run time. When the counter expires, the handshake is abandoned. Three status outputs report the result: busy, done and timeout.

Top module: `recal_handshake`

## Requirements
- R1: While `rst` is high at a clock edge, the block goes to idle on that edge: the outgoing bus reads 0x00, and busy, done and timeout all read 0.
- R2: A start pulse taken while idle drives the outgoing bus to the request code 0x0F on the next cycle and raises busy.
- R3: During the first wait, a return value of 0x07 (request seen) moves the block to the completion wait. The outgoing bus stays at 0x0F.
- R4: During the completion wait, a return value of 0x08 (work finished) makes the outgoing bus drop to 0x00. Busy stays high.
- R5: During the final wait, a return value of 0x00 ends the handshake: busy falls and done is set.
- R6: A return value is acted on only when the synchronized value is the same on two consecutive samples. A single-cycle value is ignored.
- R7: A start pulse while busy is ignored: the outgoing bus and the phase are not changed.
- R8: If a wait phase has lasted `tmo_limit_i` cycles after its first cycle, the next clock edge aborts the handshake. The outgoing bus becomes 0x00, busy falls, and the sticky timeout flag is set. With a start taken at edge e0 and no progress, timeout rises at edge e0+limit+1.
- R9: A start taken while idle clears both the done flag and the timeout flag.
- R10: A return code that does not belong to the current phase is ignored. For example, 0x08 during the first wait does not count as completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to begin a handshake |
| tmo_limit_i | input | TMO_W | Wait-phase timeout limit in cycles |
| from_seq_i | input | 8 | Return bus from the sequencer (asynchronous) |
| to_seq_o | output | 8 | Registered outgoing bus to the sequencer |
| busy_o | output | 1 | Handshake in progress |
| done_o | output | 1 | Sticky: last handshake completed normally |
| timeout_o | output | 1 | Sticky: last handshake was aborted by the timer |

## Verification
Full handshakes are run with a well-behaved responder. These show that each code moves the block by exactly one phase, and that done and timeout are set and cleared correctly.

A sweep of every timeout limit from 1 to 8 with a silent responder checks the exact abort edge, one cycle before and at expiry. This separates an off-by-one in the counter from a correct design.

Three further patterns each isolate one input filter:
- a one-cycle 0x07 glitch followed by a steady 0x08, which separates the stability filter from a plain synchronizer;
- a 0x08 presented before any 0x07, which separates strict phase decoding from loose decoding;
- a start pulse during the final phase, which shows that starts are ignored while busy.

// File: rtl/recal_pkg.sv
package recal_pkg;

    localparam int BUS_W = 8;

    typedef logic [BUS_W-1:0] code_t;

    localparam code_t CODE_REQ  = 8'h0F;
    localparam code_t CODE_ACK  = 8'h07;
    localparam code_t CODE_DONE = 8'h08;
    localparam code_t CODE_IDLE = 8'h00;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ACK,
        PH_DONE,
        PH_CLR
    } phase_e;

    typedef struct packed {
        logic  stable;
        code_t code;
    } rx_s;

    function automatic logic code_hit(rx_s r, code_t c);
        return r.stable && (r.code == c);
    endfunction

    function automatic code_t drive_for(phase_e p);
        case (p)
            PH_ACK, PH_DONE: return CODE_REQ;
            default:         return CODE_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/recal_rx_filter.sv
module recal_rx_filter
    import recal_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  code_t raw_i,
    output rx_s   rx_o
);

    code_t sync1_q;
    code_t sync2_q;
    code_t prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1_q <= CODE_IDLE;
            sync2_q <= CODE_IDLE;
            prev_q  <= CODE_IDLE;
        end else begin
            sync1_q <= raw_i;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
        end
    end

    always_comb begin
        rx_o.code   = sync2_q;
        rx_o.stable = (sync2_q == prev_q);
    end

    // R6
    stable_two_samples_chk: assert property (@(posedge clk) disable iff (rst)
        rx_o.stable |-> (rx_o.code == $past(sync2_q)));

endmodule

// File: rtl/recal_timer.sv
module recal_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    input  logic [W-1:0] limit_i,
    output logic         expired_o
);

    logic [W-1:0] cnt_q;

    assign expired_o = (cnt_q >= limit_i);

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
        end else if (!expired_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R8
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && expired_o && $stable(limit_i)) |=> (cnt_q == $past(cnt_q)));

endmodule

// File: rtl/recal_handshake.sv
module recal_handshake
    import recal_pkg::*;
#(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [TMO_W-1:0] tmo_limit_i,
    input  logic [7:0]       from_seq_i,
    output logic [7:0]       to_seq_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             timeout_o
);

    rx_s    rx;
    phase_e phase_q, phase_d;
    code_t  out_q;
    logic   done_q, tmo_q;
    logic   tmr_clr, tmr_exp;
    logic   finish, abort, accept;

    recal_rx_filter i_filter (
        .clk   (clk),
        .rst   (rst),
        .raw_i (from_seq_i),
        .rx_o  (rx)
    );

    recal_timer #(.W(TMO_W)) i_timer (
        .clk       (clk),
        .rst       (rst),
        .clr_i     (tmr_clr),
        .limit_i   (tmo_limit_i),
        .expired_o (tmr_exp)
    );

    always_comb begin
        phase_d = phase_q;
        tmr_clr = 1'b0;
        finish  = 1'b0;
        abort   = 1'b0;
        accept  = 1'b0;
        case (phase_q)
            PH_IDLE: begin
                tmr_clr = 1'b1;
                if (start_i) begin
                    phase_d = PH_ACK;
                    accept  = 1'b1;
                end
            end
            PH_ACK: begin
                if (code_hit(rx, CODE_ACK)) begin
                    phase_d = PH_DONE;
                    tmr_clr = 1'b1;
                end else if (tmr_exp) begin
                    phase_d = PH_IDLE;
                    abort   = 1'b1;
                end
            end
            PH_DONE: begin
                if (code_hit(rx, CODE_DONE)) begin
                    phase_d = PH_CLR;
                    tmr_clr = 1'b1;
                end else if (tmr_exp) begin
                    phase_d = PH_IDLE;
                    abort   = 1'b1;
                end
            end
            PH_CLR: begin
                if (code_hit(rx, CODE_IDLE)) begin
                    phase_d = PH_IDLE;
                    finish  = 1'b1;
                end else if (tmr_exp) begin
                    phase_d = PH_IDLE;
                    abort   = 1'b1;
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            out_q   <= CODE_IDLE;
            done_q  <= 1'b0;
            tmo_q   <= 1'b0;
        end else begin
            phase_q <= phase_d;
            out_q   <= drive_for(phase_d);
            if (accept) begin
                done_q <= 1'b0;
                tmo_q  <= 1'b0;
            end
            if (finish) done_q <= 1'b1;
            if (abort)  tmo_q  <= 1'b1;
        end
    end

    assign to_seq_o  = out_q;
    assign busy_o    = (phase_q != PH_IDLE);
    assign done_o    = done_q;
    assign timeout_o = tmo_q;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (to_seq_o == CODE_IDLE) && !busy_o && !done_o && !timeout_o);

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> (to_seq_o == CODE_REQ) && busy_o && !done_o && !timeout_o);

    // R5
    done_release_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> !busy_o && (to_seq_o == CODE_IDLE));

    // R8
    abort_release_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout_o) |-> !busy_o && (to_seq_o == CODE_IDLE));

    // R7
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i && (to_seq_o == CODE_IDLE)) |=> (to_seq_o == CODE_IDLE));

endmodule

// File: tb/test_recal_handshake.sv
module test_recal_handshake;

    localparam int CLK_PERIOD = 10;
    localparam int TW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic [TW-1:0] limit;
    logic [7:0]    from_seq;
    logic [7:0]    to_seq;
    logic          busy, done, tmo;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    recal_handshake #(.TMO_W(TW)) i_recal_handshake (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start),
        .tmo_limit_i (limit),
        .from_seq_i  (from_seq),
        .to_seq_o    (to_seq),
        .busy_o      (busy),
        .done_o      (done),
        .timeout_o   (tmo)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        start = 1'b1;
        tick(1);
        start = 1'b0;
    endtask

    task automatic full_run(input int lim);
        limit = lim[TW-1:0];
        from_seq = 8'h00;
        pulse_start();
        chk("R2 req code", to_seq, 8'h0F);
        chk("R2 busy", busy, 1);
        chk("R9 done cleared", done, 0);
        chk("R9 timeout cleared", tmo, 0);
        from_seq = 8'h07;
        tick(6);
        chk("R3 still requesting", to_seq, 8'h0F);
        from_seq = 8'h08;
        tick(6);
        chk("R4 request withdrawn", to_seq, 8'h00);
        chk("R4 busy", busy, 1);
        from_seq = 8'h00;
        tick(6);
        chk("R5 busy low", busy, 0);
        chk("R5 done", done, 1);
        chk("R5 no timeout", tmo, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        start = 1'b0;
        limit = 8'd20;
        from_seq = 8'h00;
        tick(3);
        chk("R1 out", to_seq, 8'h00);
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 timeout", tmo, 0);
        rst = 1'b0;
        tick(2);

        full_run(20);
        full_run(12);

        // R8: exact abort edge for each limit; R9 clears the flag on restart
        for (int lim = 1; lim <= 8; lim++) begin
            limit = lim[TW-1:0];
            from_seq = 8'h00;
            pulse_start();
            tick(lim);
            chk("R8 before expiry", tmo, 0);
            chk("R8 busy before expiry", busy, 1);
            tick(1);
            chk("R8 timeout", tmo, 1);
            chk("R8 busy low", busy, 0);
            chk("R8 out idle", to_seq, 8'h00);
            tick(2);
        end
        limit = 8'd20;
        pulse_start();
        chk("R9 timeout cleared by start", tmo, 0);
        tick(30);
        chk("R8 aborted again", tmo, 1);

        // R7: start during final phase is ignored
        limit = 8'd40;
        from_seq = 8'h00;
        pulse_start();
        from_seq = 8'h07;
        tick(6);
        from_seq = 8'h08;
        tick(6);
        chk("R7 in final phase", to_seq, 8'h00);
        pulse_start();
        chk("R7 start ignored", to_seq, 8'h00);
        tick(2);
        chk("R7 still idle code", to_seq, 8'h00);
        from_seq = 8'h00;
        tick(6);
        chk("R7 completes", done, 1);

        // R6: one-cycle ack glitch is not accepted
        limit = 8'd60;
        pulse_start();
        tick(2);
        from_seq = 8'h07;
        tick(1);
        from_seq = 8'h08;
        tick(15);
        chk("R6 glitch ignored out", to_seq, 8'h0F);
        chk("R6 glitch ignored busy", busy, 1);
        from_seq = 8'h00;
        tick(70);
        chk("R6 ends by timeout", tmo, 1);

        // R10: completion code before ack is ignored
        limit = 8'd60;
        pulse_start();
        from_seq = 8'h08;
        tick(10);
        chk("R10 early done ignored", to_seq, 8'h0F);
        from_seq = 8'h07;
        tick(8);
        chk("R10 ack accepted", to_seq, 8'h0F);
        from_seq = 8'h08;
        tick(8);
        chk("R10 done accepted", to_seq, 8'h00);
        from_seq = 8'h00;
        tick(8);
        chk("R10 complete", done, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule